// File: doc/BRIEF.md
# Multi-Source Interrupt Level Controller

This block gathers up to 31 level-sensitive system interrupt lines and turns them into a 4-bit processor interrupt level for each of several CPUs. A global mask word decides which lines may be delivered. A set bit blocks its line. Bit 31 of the mask is a master block over every global line. Each unmasked active line is mapped to a processor level through a fixed table. Several lines share most levels, so software reads the raw pending word to find out which one fired.

Device lines go only to the CPU named in a target register. The four error lines raise level 15 on every CPU. Each CPU also has its own word in a small bank. That word holds fifteen software interrupt bits and an enable for that CPU's level-14 timer request. Each CPU's level output is the highest level it has pending, held in a register. A simple single-cycle register port gives software access: writes take effect at the clock edge and reads are combinational.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every mask bit reads 1 (32'hFFFF_FFFF), the target reads 0, every per-CPU word reads 0 and every CPU level output is 0.
- R2: A write to global offset 2 sets each mask bit that has a 1 in the data. A write to offset 3 clears each mask bit that has a 1 in the data. Bits written as 0 keep their value. The mask reads back at offset 1. Global offsets use address bit 4 = 0 and address bits 2:0.
- R3: A source whose mask bit is 1 adds nothing to any level. While mask bit 31 is 1, no global source (device or error) is delivered.
- R4: Onboard lines map to levels as follows: bit 18 to 4, bit 16 to 6, bit 20 to 8, bit 21 to 9, bit 19 to 10, bit 22 to 11, bits 15 and 14 to 12, and bit 17 to 13.
- R5: Bus level n (n = 1 to 7) arrives on bit n+6 of one bus group and on bit n-1 of the other. Bus levels 1 to 7 map to processor levels 2, 3, 5, 7, 9, 11 and 13, in that order.
- R6: An unmasked active error line (bits 30, 29, 28 or 27) drives level 15 on every CPU, whatever the target is.
- R7: Device levels go only to the CPU whose index is held in the target register (global offset 4, low bits). All other CPUs see nothing from device lines.
- R8: Each CPU word sits at address {1, cpu, sub}. sub 0 reads the word, sub 1 sets bits and sub 2 clears bits. Bit k+16 (k = 1 to 15) is a software request at level k for that CPU only. Writes to a word's set and clear ports only touch bits 31:17 and 7.
- R9: Bit 7 of a CPU word enables that CPU's timer input, which then requests level 14 on that CPU only.
- R10: Each CPU's level is the highest of its requests, or 0 when it has none. The level is registered, so it follows its inputs one clock later.
- R11: Global offset 0 reads the raw source lines 30:0, with bit 31 read as 0. Lines 23 to 26 never raise a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive global interrupt lines (bit 31 unused) |
| tmr_i | input | NCPU | Per-CPU level-14 timer requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_level_o | output | 4*NCPU | Per-CPU interrupt level, CPU c in bits 4c+3:4c |

## Verification
The hardest state to reach is a mix that needs several things true at once. A device line must be unmasked, routed to a non-zero target and overlapping a software request or a timer on another CPU, while the master block is released. With every mask bit set at reset, random data alone almost never gets there. The stimulus therefore biases its clear-port writes toward bit 31 and keeps error lines rare, so that device priority stays visible. Directed steps first walk each line of the level map and each routing and blocking corner one at a time.

// File: rtl/irqc_pkg.sv
// Shared constants and the source-to-level map for the interrupt level controller.
// Assumes a 32-bit source word with bit 31 reserved as the master block.
package irqc_pkg;
    localparam int DW     = 32;
    localparam int LVL_W  = 4;
    localparam int NLVL   = 16;
    localparam logic [DW-1:0] ERR_BITS  = 32'h7800_0000;
    localparam logic [DW-1:0] PCPU_BITS = 32'hFFFE_0080;
    localparam int TMR_EN_BIT = 7;
    localparam int SOFT_BASE  = 16;
    localparam int MASK_ALL   = 31;

    // Global register offsets
    localparam logic [2:0] G_PEND = 3'd0;
    localparam logic [2:0] G_MASK = 3'd1;
    localparam logic [2:0] G_SET  = 3'd2;
    localparam logic [2:0] G_CLR  = 3'd3;
    localparam logic [2:0] G_TGT  = 3'd4;
    // Per-CPU sub offsets
    localparam logic [1:0] P_READ = 2'd0;
    localparam logic [1:0] P_SET  = 2'd1;
    localparam logic [1:0] P_CLR  = 2'd2;

    // Level for bus level n (1..7)
    function automatic logic [LVL_W-1:0] bus_level(input int n);
        case (n)
            1: return 4'd2;
            2: return 4'd3;
            3: return 4'd5;
            4: return 4'd7;
            5: return 4'd9;
            6: return 4'd11;
            7: return 4'd13;
            default: return 4'd0;
        endcase
    endfunction

    // Processor level of global source bit idx; 0 means never delivered
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        if (idx >= 27 && idx <= 30) return 4'd15;
        if (idx <= 6)               return bus_level(idx + 1);
        if (idx >= 7 && idx <= 13)  return bus_level(idx - 6);
        case (idx)
            14, 15: return 4'd12;
            16:     return 4'd6;
            17:     return 4'd13;
            18:     return 4'd4;
            19:     return 4'd10;
            20:     return 4'd8;
            21:     return 4'd9;
            22:     return 4'd11;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/irqc_gmask.sv
// Global mask word (set/clear ports) and device target register.
// Assumes at most one of the write strobes is active per cycle.
module irqc_gmask
    import irqc_pkg::*;
#(
    parameter int CPUW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic            wr_tgt,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   mask_q,
    output logic [CPUW-1:0] tgt_q
);
    // Mask register: reset to all blocked, ones in data set or clear bits
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (wr_set) mask_q <= mask_q | wdata;
        else if (wr_clr) mask_q <= mask_q & ~wdata;
    end

    // Target register: CPU index that receives device levels
    always_ff @(posedge clk) begin
        if (!rst_n)      tgt_q <= '0;
        else if (wr_tgt) tgt_q <= wdata[CPUW-1:0];
    end
endmodule

// File: rtl/irqc_pcpu_bank.sv
// Bank of per-CPU words holding software requests and the timer enable.
// Assumes one-hot (or zero) strobes; only PCPU_BITS are storable.
module irqc_pcpu_bank
    import irqc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCPU-1:0]          wr_set,
    input  logic [NCPU-1:0]          wr_clr,
    input  logic [DW-1:0]            wdata,
    output logic [NCPU-1:0][DW-1:0]  bank_q
);
    for (genvar c = 0; c < NCPU; c++) begin : g_word
        // One word per CPU, set/clear limited to the implemented bits
        always_ff @(posedge clk) begin
            if (!rst_n)         bank_q[c] <= '0;
            else if (wr_set[c]) bank_q[c] <= bank_q[c] | (wdata & PCPU_BITS);
            else if (wr_clr[c]) bank_q[c] <= bank_q[c] & ~(wdata & PCPU_BITS);
        end
    end
endmodule

// File: rtl/irqc_lvl_enc.sv
// Priority encoder: highest set request among levels 1..15, 0 if none.
// Assumes request bit 0 is unused.
module irqc_lvl_enc
    import irqc_pkg::*;
(
    input  logic [NLVL-1:0]  req,
    output logic [LVL_W-1:0] level
);
    // Ascending scan, so the last hit is the highest level
    always_comb begin
        level = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (req[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Top of the interrupt level controller: register decode, global source
// mapping, per-CPU request merge and registered level outputs.
// Assumes a single-cycle register port with combinational reads.
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter  int NCPU   = 4,
    localparam int CPUW   = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ADDR_W = 1 + (((CPUW + 2) > 3) ? (CPUW + 2) : 3)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         src_i,
    input  logic [NCPU-1:0]       tmr_i,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic [NCPU*LVL_W-1:0] cpu_level_o
);
    logic                    pspace;
    logic [2:0]              goff;
    logic [1:0]              poff;
    logic [CPUW-1:0]         pidx;
    logic                    g_set, g_clr, g_tgt;
    logic [NCPU-1:0]         p_set, p_clr;
    logic [DW-1:0]           mask_q;
    logic [CPUW-1:0]         tgt_q;
    logic [NCPU-1:0][DW-1:0] pcpu_q;
    logic [NLVL-1:0]         dev_req, err_req;
    logic [NCPU-1:0]         tmr_req;

    assign pspace = reg_addr[ADDR_W-1];
    assign goff   = reg_addr[2:0];
    assign poff   = reg_addr[1:0];
    assign pidx   = reg_addr[CPUW+1:2];

    // Write strobe decode for global and per-CPU spaces
    always_comb begin
        g_set = reg_wr && !pspace && goff == G_SET;
        g_clr = reg_wr && !pspace && goff == G_CLR;
        g_tgt = reg_wr && !pspace && goff == G_TGT;
        p_set = '0;
        p_clr = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (reg_wr && pspace && pidx == CPUW'(c)) begin
                p_set[c] = poff == P_SET;
                p_clr[c] = poff == P_CLR;
            end
        end
    end

    irqc_gmask #(.CPUW(CPUW)) u_gmask (
        .clk(clk), .rst_n(rst_n), .wr_set(g_set), .wr_clr(g_clr),
        .wr_tgt(g_tgt), .wdata(reg_wdata), .mask_q(mask_q), .tgt_q(tgt_q)
    );

    irqc_pcpu_bank #(.NCPU(NCPU)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_set(p_set), .wr_clr(p_clr),
        .wdata(reg_wdata), .bank_q(pcpu_q)
    );

    // Read mux: raw pending, mask, target, or a per-CPU word
    always_comb begin
        reg_rdata = '0;
        if (!pspace) begin
            case (goff)
                G_PEND:  reg_rdata = {1'b0, src_i[DW-2:0]};
                G_MASK:  reg_rdata = mask_q;
                G_TGT:   reg_rdata = DW'(tgt_q);
                default: reg_rdata = '0;
            endcase
        end else if (poff == P_READ && int'(pidx) < NCPU) begin
            reg_rdata = pcpu_q[pidx];
        end
    end

    // Map unmasked global lines onto device and broadcast error levels
    always_comb begin
        dev_req = '0;
        err_req = '0;
        for (int i = 0; i < DW - 1; i++) begin
            if (src_i[i] && !mask_q[i] && !mask_q[MASK_ALL]
                && src_level(i) != '0) begin
                if (ERR_BITS[i]) err_req[src_level(i)] = 1'b1;
                else             dev_req[src_level(i)] = 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NLVL-1:0]  req;
        logic [LVL_W-1:0] lvl_d;

        assign tmr_req[c] = tmr_i[c] && pcpu_q[c][TMR_EN_BIT];

        // Merge broadcast, routed device, software and timer requests
        always_comb begin
            req = err_req;
            if (tgt_q == CPUW'(c)) req = req | dev_req;
            req[NLVL-1:1] = req[NLVL-1:1] | pcpu_q[c][DW-1:SOFT_BASE+1];
            if (tmr_req[c]) req[14] = 1'b1;
            req[0] = 1'b0;
        end

        irqc_lvl_enc u_enc (.req(req), .level(lvl_d));

        // Registered level output for this CPU
        always_ff @(posedge clk) begin
            if (!rst_n) cpu_level_o[c*LVL_W +: LVL_W] <= '0;
            else        cpu_level_o[c*LVL_W +: LVL_W] <= lvl_d;
        end
    end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Property checker for irq_level_ctrl, attached with bind below.
module irq_level_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int ADDR_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [DW-1:0]           src_i,
    input logic [NCPU-1:0]         tmr_i,
    input logic                    reg_wr,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [DW-1:0]           reg_wdata,
    input logic [DW-1:0]           mask_q,
    input logic [NCPU-1:0][DW-1:0] pcpu_q,
    input logic [NCPU*LVL_W-1:0]   cpu_level_o
);
    logic g_set_w, g_clr_w, err_live;
    assign g_set_w  = reg_wr && !reg_addr[ADDR_W-1] && reg_addr[2:0] == G_SET;
    assign g_clr_w  = reg_wr && !reg_addr[ADDR_W-1] && reg_addr[2:0] == G_CLR;
    assign err_live = |(src_i & ~mask_q & ERR_BITS) && !mask_q[MASK_ALL];

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && cpu_level_o == '0));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        g_set_w |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

    p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        g_clr_w |=> ((mask_q & $past(reg_wdata)) == '0));

    p_err_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_live) |-> (cpu_level_o == {NCPU{4'hF}}));

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        p_mask_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mask_q[MASK_ALL] && pcpu_q[c][DW-1:SOFT_BASE+1] == '0
                  && !(tmr_i[c] && pcpu_q[c][TMR_EN_BIT]))
            |-> cpu_level_o[c*LVL_W +: LVL_W] == '0);

        p_soft15_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pcpu_q[c][DW-1]) |-> cpu_level_o[c*LVL_W +: LVL_W] == 4'd15);

        p_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(tmr_i[c] && pcpu_q[c][TMR_EN_BIT])
            |-> cpu_level_o[c*LVL_W +: LVL_W] >= 4'd14);
    end
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .tmr_i(tmr_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mask_q(mask_q),
    .pcpu_q(pcpu_q), .cpu_level_o(cpu_level_o)
);

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [3:0]  tmr_i = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] cpu_level_o;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic [31:0] m_mask;
    logic [1:0]  m_tgt;
    logic [31:0] m_pc [NCPU];

    irq_level_ctrl #(.NCPU(NCPU)) u_irq_level_ctrl (.*);

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    function automatic logic [3:0] ref_map(input int b);
        logic [3:0] bl [7] = '{4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13};
        if (b >= 27 && b <= 30) return 4'd15;
        if (b <= 6) return bl[b];
        if (b <= 13) return bl[b - 7];
        case (b)
            14, 15: return 4'd12;
            16: return 4'd6;  17: return 4'd13; 18: return 4'd4;
            19: return 4'd10; 20: return 4'd8;  21: return 4'd9;
            22: return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] ref_lvl(input int c);
        logic [3:0] best = 0;
        for (int b = 0; b < 31; b++) begin
            if (src_i[b] && !m_mask[b] && !m_mask[31]) begin
                if ((b >= 27 || c == int'(m_tgt)) && ref_map(b) > best)
                    best = ref_map(b);
            end
        end
        for (int k = 1; k < 16; k++) if (m_pc[c][k+16] && 4'(k) > best) best = 4'(k);
        if (tmr_i[c] && m_pc[c][7] && best < 14) best = 4'd14;
        return best;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 5'd2) m_mask = m_mask | d;
        else if (a == 5'd3) m_mask = m_mask & ~d;
        else if (a == 5'd4) m_tgt = d[1:0];
        else if (a[4] && a[1:0] == 2'd1) m_pc[a[3:2]] = m_pc[a[3:2]] | (d & 32'hFFFE_0080);
        else if (a[4] && a[1:0] == 2'd2) m_pc[a[3:2]] = m_pc[a[3:2]] & ~(d & 32'hFFFE_0080);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_lv(input string req);
        logic [15:0] e;
        @(negedge clk);
        for (int c = 0; c < NCPU; c++) e[c*4 +: 4] = ref_lvl(c);
        chk(cpu_level_o == e, req, 32'(cpu_level_o), 32'(e));
    endtask

    // Directed single-line check against a literal level on the target CPU
    task automatic one(input int b, input logic [3:0] lv, input string req);
        @(negedge clk); src_i = 32'h1 << b;
        @(negedge clk);
        chk(cpu_level_o[int'(m_tgt)*4 +: 4] == lv, req,
            32'(cpu_level_o), 32'(lv));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        m_mask = '1; m_tgt = 0;
        for (int c = 0; c < NCPU; c++) m_pc[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_level_o == '0, "R1 levels", 32'(cpu_level_o), 0);
        rd(5'd1, d); chk(d == 32'hFFFF_FFFF, "R1 mask", d, 32'hFFFF_FFFF);
        rd(5'd4, d); chk(d == 0, "R1 target", d, 0);
        for (int c = 0; c < NCPU; c++) begin
            rd({1'b1, 2'(c), 2'd0}, d); chk(d == 0, "R1 pcpu", d, 0);
        end
        // R2 set/clear behaviour
        wr(5'd3, 32'h0000_F00F); rd(5'd1, d);
        chk(d == 32'hFFFF_0FF0, "R2 clear", d, 32'hFFFF_0FF0);
        wr(5'd2, 32'h0000_0003); rd(5'd1, d);
        chk(d == 32'hFFFF_0FF3, "R2 set", d, 32'hFFFF_0FF3);
        wr(5'd2, 32'h0); rd(5'd1, d);
        chk(d == 32'hFFFF_0FF3, "R2 zero write", d, 32'hFFFF_0FF3);
        // R3 master block holds everything
        src_i = 32'h0000_F00C; chk_lv("R3 mask-all");
        chk(cpu_level_o == 0, "R3 mask-all zero", 32'(cpu_level_o), 0);
        wr(5'd3, 32'hFFFF_FFFF);
        // R4 onboard map
        one(18, 4'd4, "R4 bit18"); one(16, 4'd6, "R4 bit16");
        one(20, 4'd8, "R4 bit20"); one(21, 4'd9, "R4 bit21");
        one(19, 4'd10, "R4 bit19"); one(22, 4'd11, "R4 bit22");
        one(15, 4'd12, "R4 bit15"); one(14, 4'd12, "R4 bit14");
        one(17, 4'd13, "R4 bit17");
        // R5 both bus groups
        one(7, 4'd2, "R5 busA1"); one(13, 4'd13, "R5 busA7");
        one(9, 4'd5, "R5 busA3"); one(0, 4'd2, "R5 busB1");
        one(3, 4'd7, "R5 busB4"); one(6, 4'd13, "R5 busB7");
        // R11 unused lines and pending readback
        one(24, 4'd0, "R11 unused");
        src_i = 32'hFFFF_FFFF; rd(5'd0, d);
        chk(d == 32'h7FFF_FFFF, "R11 pending", d, 32'h7FFF_FFFF);
        // R3 single-bit mask
        wr(5'd2, 32'h0004_0000);
        one(18, 4'd0, "R3 masked bit18");
        // R7 routing to CPU 2
        wr(5'd4, 32'd2);
        src_i = 32'h0010_0000; chk_lv("R7 route");
        chk(cpu_level_o == 16'h0800, "R7 cpu2 only", 32'(cpu_level_o), 32'h0800);
        // R10 highest wins
        src_i = 32'h0011_0001; chk_lv("R10 highest");
        chk(cpu_level_o == 16'h0800, "R10 highest value", 32'(cpu_level_o), 32'h0800);
        // R6 error broadcast
        src_i = 32'h1000_0000; chk_lv("R6 err");
        chk(cpu_level_o == 16'hFFFF, "R6 all 15", 32'(cpu_level_o), 32'hFFFF);
        src_i = 0;
        // R8 software requests, and bits outside the word ignored
        wr({1'b1, 2'd1, 2'd1}, 32'h0020_0001); chk_lv("R8 soft5 cpu1");
        chk(cpu_level_o == 16'h0050, "R8 soft5", 32'(cpu_level_o), 32'h0050);
        rd({1'b1, 2'd1, 2'd0}, d); chk(d == 32'h0020_0000, "R8 readback", d, 32'h0020_0000);
        wr({1'b1, 2'd1, 2'd2}, 32'h0020_0000); chk_lv("R8 soft clear");
        // R9 timer enable
        tmr_i = 4'b1000; chk_lv("R9 timer disabled");
        wr({1'b1, 2'd3, 2'd1}, 32'h0000_0080); chk_lv("R9 timer enabled");
        chk(cpu_level_o == 16'hE000, "R9 level14", 32'(cpu_level_o), 32'hE000);
        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0: begin
                    @(negedge clk);
                    src_i = $urandom;
                    if ($urandom_range(0, 7) != 0) src_i &= ~32'h7800_0000;
                end
                1: wr(5'd2, $urandom & $urandom);
                2: wr(5'd3, ($urandom_range(0, 1) ? 32'h8000_0000 : 0) | $urandom);
                3: wr(5'd4, 32'($urandom_range(0, 3)));
                4: wr({1'b1, 2'($urandom_range(0, 3)), 2'($urandom_range(1, 2))},
                      $urandom & $urandom);
                default: begin @(negedge clk); tmr_i = 4'($urandom); end
            endcase
            chk_lv("R10 random");
            if (it % 50 == 0) begin
                rd(5'd1, d); chk(d == m_mask, "R2 random mask", d, m_mask);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule